// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits between the pins of a 32-bit-wide memory and its array. It produces the sequence of array addresses for a synchronous burst read, together with a ready strobe and an output-enable qualifier, all timed against an external read clock. A 16-bit configuration word sets the access mode, the initial latency, the burst length, the address ordering, the ready timing and the clock edge on which results are presented.

After reset the block is in asynchronous mode and never starts a burst. Once software writes a synchronous configuration, a clock edge that sees both chip enable and latch enable low captures the address and starts the initial wait. Beats then advance on each edge where the advance input is low. The word data itself comes from the array, which is outside this block.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the block is in asynchronous mode, with `rdy_n` high, `data_oe` low and `cfg_err` low. In asynchronous mode a latch never starts a burst.
- R2: Configuration fields: bit 15 selects the mode (1 asynchronous, 0 synchronous). Bits 13:11 hold latency code c, giving latency L = c+1 for c from 2 to 7. Bit 9 = 1 selects early ready. Bit 7 = 1 selects rising-edge presentation and 0 selects falling-edge presentation. Bit 3 = 1 selects no-wrap. Bit 2 = 1 selects 8 beats and 0 selects 4 beats. The reset word is 16'h9000. A write with `cfg_we` high takes effect at the next rising edge.
- R3: A burst starts only at a rising edge where `ce_n` and `lat_n` are both low, and `addr` is captured at that edge. The first beat is presented after the rising edge L edges later. `data_oe` is high exactly while a beat is presented, and `arr_addr` then holds that beat's address.
- R4: In wrap mode each beat moves to the next address inside the aligned 4- or 8-word group (start 6, 4 beats: 6,7,4,5).
- R5: In no-wrap mode beats run linearly from the start address and cross group boundaries (start 6, 8 beats: 6..13).
- R6: A burst ends after the last beat (4th or 8th) is advanced past, and `data_oe` then falls.
- R7: At an edge where `adv_n` is high during a burst, the address and beat are held.
- R8: With normal ready timing, `rdy_n` is low exactly while a beat is presented.
- R9: With early ready timing, `rdy_n` is low one cycle ahead of the beats: during the last wait cycle and on every beat except the final one.
- R10: In falling-edge mode the outputs change at the falling clock edge that follows the rising edge where the sequencer updated. In rising-edge mode they change at that rising edge.
- R11: A configuration write whose latency code is 0 or 1 is rejected, so the previous configuration stays in force. It also sets `cfg_err`, which stays set until reset.
- R12: While `ce_n` is high, `rdy_n` is high and `data_oe` is low at once. The burst is abandoned at the next rising edge.
- R13: A new latch during a burst or a wait aborts it and restarts from the new address with a full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| lat_n | input | 1 | Address latch strobe, active low |
| addr | input | ADDR_W | Start address |
| adv_n | input | 1 | Burst advance, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 16 | Configuration word |
| arr_addr | output | ADDR_W | Array address of the current beat |
| rdy_n | output | 1 | Ready strobe, active low |
| data_oe | output | 1 | Output-enable qualifier for the data bus |
| cfg_err | output | 1 | Sticky flag for a rejected configuration |

## Verification
The hardest state to reach from the ports is a burst interrupted partway through while holds are pending and the wait and beat counters are non-zero. In that state a relatch or a chip-enable release must cancel it, and the result must hold under every mix of latency, length, wrap, ready and edge options. The stimulus reaches this state by writing a random legal configuration before each burst. It then drives the advance input with random holds, and injects relatches and chip-enable pulses at random cycles. Directed sequences cover the group-boundary orderings, the half-cycle shift of the falling-edge mode and the rejected latency codes.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;

  localparam int CFG_W        = 16;
  localparam int LAT_W        = 3;
  localparam int BIT_MODE     = 15;
  localparam int LAT_HI       = 13;
  localparam int LAT_LO       = 11;
  localparam int BIT_RDY      = 9;
  localparam int BIT_EDGE     = 7;
  localparam int BIT_NOWRAP   = 3;
  localparam int BIT_LONG     = 2;
  localparam logic [LAT_W-1:0] LAT_MIN_CODE = 3'd2;
  localparam logic [CFG_W-1:0] CFG_RESET    = 16'h9000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } bsq_state_t;

  typedef struct packed {
    logic             async_md;
    logic [LAT_W-1:0] lat_code;
    logic             rdy_early;
    logic             rise_edge;
    logic             no_wrap;
    logic             long_burst;
  } bsq_cfg_t;

  function automatic bsq_cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    bsq_cfg_t c;
    c.async_md   = w[BIT_MODE];
    c.lat_code   = w[LAT_HI:LAT_LO];
    c.rdy_early  = w[BIT_RDY];
    c.rise_edge  = w[BIT_EDGE];
    c.no_wrap    = w[BIT_NOWRAP];
    c.long_burst = w[BIT_LONG];
    return c;
  endfunction

endpackage

// File: rtl/bsq_cfg_reg.sv
`timescale 1ns/1ps
module bsq_cfg_reg
  import bsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] word,
  output bsq_cfg_t         cfg_o,
  output logic             err_o
);

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             err_q, err_d;
  logic             lat_bad, cfg_en, err_set;

  always_comb begin
    lat_bad = (word[LAT_HI:LAT_LO] < LAT_MIN_CODE);
    cfg_en  = we & ~lat_bad;
    err_set = we & lat_bad;
    cfg_d   = cfg_en ? word : cfg_q;
    err_d   = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg_o = cfg_decode(cfg_q);
  assign err_o = err_q;

  // R11
  lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o.lat_code >= LAT_MIN_CODE);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/bsq_addr_step.sv
`timescale 1ns/1ps
module bsq_addr_step #(
  parameter int AW        = 20,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8
) (
  input  logic [AW-1:0] cur,
  input  logic          long_burst,
  input  logic          no_wrap,
  output logic [AW-1:0] nxt
);

  localparam int SB = $clog2(SHORT_LEN);
  localparam int LB = $clog2(LONG_LEN);

  logic [AW-1:0] lin;
  assign lin = cur + AW'(1);

  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i < SB) begin : g_low
      assign nxt[i] = lin[i];
    end else if (i < LB) begin : g_mid
      assign nxt[i] = (no_wrap | long_burst) ? lin[i] : cur[i];
    end else begin : g_high
      assign nxt[i] = no_wrap ? lin[i] : cur[i];
    end
  end

endmodule

// File: rtl/bsq_ctrl.sv
`timescale 1ns/1ps
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             lat_n,
  input  logic             adv_n,
  input  logic [AW-1:0]    addr_i,
  input  logic             async_md,
  input  logic [LAT_W-1:0] lat_code,
  input  logic             rdy_early,
  input  logic             long_burst,
  input  logic [AW-1:0]    step_addr,
  output logic [AW-1:0]    cur_addr,
  output logic             dval,
  output logic             rdy_n
);

  localparam int BW = $clog2(LONG_LEN);

  bsq_state_t       st_q, st_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [BW-1:0]    beat_q, beat_d, last_beat;
  logic [AW-1:0]    addr_q, addr_d;
  logic             addr_en;
  logic             dval_q, dval_d;
  logic             rdy_n_q, rdy_n_d;
  logic             rdy_on;

  always_comb begin
    last_beat = long_burst ? BW'(LONG_LEN - 1) : BW'(SHORT_LEN - 1);
    st_d      = st_q;
    cnt_d     = cnt_q;
    beat_d    = beat_q;
    addr_d    = addr_q;
    addr_en   = 1'b0;
    if (ce_n || async_md) begin
      st_d = ST_IDLE;
    end else if (!lat_n) begin
      st_d    = ST_WAIT;
      cnt_d   = lat_code;
      beat_d  = '0;
      addr_d  = addr_i;
      addr_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (cnt_q == '0) st_d = ST_BURST;
          else             cnt_d = cnt_q - LAT_W'(1);
        end
        ST_BURST: begin
          if (!adv_n) begin
            if (beat_q == last_beat) begin
              st_d = ST_IDLE;
            end else begin
              beat_d  = beat_q + BW'(1);
              addr_d  = step_addr;
              addr_en = 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    dval_d = (st_d == ST_BURST);
    if (rdy_early)
      rdy_on = ((st_d == ST_WAIT) && (cnt_d == '0)) ||
               ((st_d == ST_BURST) && (beat_d != last_beat));
    else
      rdy_on = (st_d == ST_BURST);
    rdy_n_d = ~rdy_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      dval_q  <= 1'b0;
      rdy_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      dval_q  <= dval_d;
      rdy_n_q <= rdy_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign cur_addr = addr_q;
  assign dval     = dval_q;
  assign rdy_n    = rdy_n_q;

  // R3
  latch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !lat_n && !async_md) |=> (st_q == ST_WAIT) && !dval_q);

  // R7
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BURST && adv_n && lat_n && !ce_n && !async_md)
      |=> $stable(addr_q) && $stable(beat_q) && dval_q);

  // R12
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dval_q && rdy_n_q);

  // R1
  async_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_md |=> (st_q == ST_IDLE));

endmodule

// File: rtl/bsq_out_stage.sv
`timescale 1ns/1ps
module bsq_out_stage #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_sel,
  input  logic [AW-1:0] addr_i,
  input  logic          dval_i,
  input  logic          rdy_n_i,
  output logic [AW-1:0] addr_o,
  output logic          dval_o,
  output logic          rdy_n_o
);

  logic [AW-1:0] addr_nq;
  logic          dval_nq;
  logic          rdy_n_nq;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_nq  <= '0;
      dval_nq  <= 1'b0;
      rdy_n_nq <= 1'b1;
    end else begin
      addr_nq  <= addr_i;
      dval_nq  <= dval_i;
      rdy_n_nq <= rdy_n_i;
    end
  end

  always_comb begin
    if (rise_sel) begin
      addr_o  = addr_i;
      dval_o  = dval_i;
      rdy_n_o = rdy_n_i;
    end else begin
      addr_o  = addr_nq;
      dval_o  = dval_nq;
      rdy_n_o = rdy_n_nq;
    end
  end

  // R10
  fall_follow_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !rise_sel |=> (dval_o == $past(dval_i)));

endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
module burst_read_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              lat_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_word,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              rdy_n,
  output logic              data_oe,
  output logic              cfg_err
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  bsq_cfg_t          cfg;
  logic [ADDR_W-1:0] step_addr, cur_addr, st_addr;
  logic              core_dval, core_rdy_n, st_dval, st_rdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  bsq_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (cfg_we),
    .word  (cfg_word),
    .cfg_o (cfg),
    .err_o (cfg_err)
  );

  bsq_addr_step #(
    .AW        (ADDR_W),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_step (
    .cur        (cur_addr),
    .long_burst (cfg.long_burst),
    .no_wrap    (cfg.no_wrap),
    .nxt        (step_addr)
  );

  bsq_ctrl #(
    .AW        (ADDR_W),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ce_n       (ce_n),
    .lat_n      (lat_n),
    .adv_n      (adv_n),
    .addr_i     (addr),
    .async_md   (cfg.async_md),
    .lat_code   (cfg.lat_code),
    .rdy_early  (cfg.rdy_early),
    .long_burst (cfg.long_burst),
    .step_addr  (step_addr),
    .cur_addr   (cur_addr),
    .dval       (core_dval),
    .rdy_n      (core_rdy_n)
  );

  bsq_out_stage #(.AW(ADDR_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rise_sel (cfg.rise_edge),
    .addr_i   (cur_addr),
    .dval_i   (core_dval),
    .rdy_n_i  (core_rdy_n),
    .addr_o   (st_addr),
    .dval_o   (st_dval),
    .rdy_n_o  (st_rdy_n)
  );

  assign arr_addr = st_addr;
  assign rdy_n    = st_rdy_n | ce_n;
  assign data_oe  = st_dval & ~ce_n;

endmodule

// File: tb/burst_read_seq_tb.sv
`timescale 1ns/1ps
module burst_read_seq_tb;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, lat_n, adv_n, cfg_we;
  logic [AW-1:0] addr;
  logic [15:0]   cfg_word;
  logic [AW-1:0] arr_addr;
  logic          rdy_n, data_oe, cfg_err;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  // model state: 0 idle, 1 wait, 2 burst
  logic [15:0]   m_cfg;
  logic          m_err;
  int            m_st, m_cnt, m_beat;
  logic [AW-1:0] m_addr;
  logic          m_rdy_low, m_first;

  always #4 clk = ~clk;

  burst_read_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lat_n(lat_n), .addr(addr),
    .adv_n(adv_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .arr_addr(arr_addr), .rdy_n(rdy_n), .data_oe(data_oe), .cfg_err(cfg_err)
  );

  function automatic logic [AW-1:0] exp_step(input logic [AW-1:0] a,
                                             input logic lng, input logic nw);
    logic [AW-1:0] mask;
    mask = lng ? AW'(7) : AW'(3);
    if (nw) return a + AW'(1);
    return (a & ~mask) | ((a + AW'(1)) & mask);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_update();
    int blen;
    blen = m_cfg[2] ? 8 : 4;
    m_first = 1'b0;
    if (ce_n || m_cfg[15]) m_st = 0;
    else if (!lat_n) begin
      m_st = 1; m_cnt = int'(m_cfg[13:11]); m_addr = addr; m_beat = 0;
    end else if (m_st == 1) begin
      if (m_cnt == 0) begin m_st = 2; m_first = 1'b1; end
      else m_cnt--;
    end else if (m_st == 2 && !adv_n) begin
      if (m_beat == blen - 1) m_st = 0;
      else begin m_beat++; m_addr = exp_step(m_addr, m_cfg[2], m_cfg[3]); end
    end
    if (m_cfg[9])
      m_rdy_low = (m_st == 1 && m_cnt == 0) || (m_st == 2 && m_beat != blen - 1);
    else
      m_rdy_low = (m_st == 2);
    if (cfg_we) begin
      if (cfg_word[13:11] >= 3'd2) m_cfg = cfg_word;
      else m_err = 1'b1;
    end
  endtask

  // entered at posedge+1; drives, samples, then moves to next posedge+1
  task automatic cyc(input logic ce, input logic lt, input logic av,
                     input logic [AW-1:0] a, input string tag);
    logic exp_oe, exp_rdy;
    ce_n = ce; lat_n = lt; adv_n = av; addr = a; cfg_we = 1'b0;
    if (!m_cfg[7] && m_first)
      chk(data_oe == 1'b0, {tag, " R10 before falling edge"}, "data_oe",
          32'(data_oe), 32'h0);
    if (m_cfg[7]) #1; else #5;
    exp_oe  = (m_st == 2) && !ce;
    exp_rdy = !m_rdy_low || ce;
    chk(data_oe == exp_oe, tag, "data_oe", 32'(data_oe), 32'(exp_oe));
    chk(rdy_n == exp_rdy, {tag, m_cfg[9] ? " R9" : " R8"}, "rdy_n",
        32'(rdy_n), 32'(exp_rdy));
    chk(cfg_err == m_err, {tag, " R11"}, "cfg_err", 32'(cfg_err), 32'(m_err));
    if (exp_oe)
      chk(arr_addr == m_addr, {tag, m_cfg[3] ? " R5" : " R4"}, "arr_addr",
          32'(arr_addr), 32'(m_addr));
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic wcfg(input logic [15:0] w);
    cfg_we = 1'b1; cfg_word = w; ce_n = 1'b1; lat_n = 1'b1; adv_n = 1'b1;
    @(posedge clk);
    model_update();
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n, input logic av, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, av, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ce_n = 1'b0; lat_n = 1'b0; adv_n = 1'b0; addr = '0;
    cfg_we = 1'b0; cfg_word = '0;
    m_cfg = 16'h9000; m_err = 1'b0; m_st = 0; m_cnt = 0; m_beat = 0;
    m_addr = '0; m_rdy_low = 1'b0; m_first = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(rdy_n == 1'b1, "R1 in reset", "rdy_n", 32'(rdy_n), 32'h1);
    chk(data_oe == 1'b0, "R1 in reset", "data_oe", 32'(data_oe), 32'h0);
    chk(cfg_err == 1'b0, "R1 in reset", "cfg_err", 32'(cfg_err), 32'h0);
    rst_n = 1'b1; ce_n = 1'b1; lat_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: asynchronous mode ignores latches
    cyc(1'b0, 1'b0, 1'b0, 20'h00010, "R1 async latch");
    run(10, 1'b0, "R1 async");

    // R11: reserved latency codes 0 and 1
    wcfg(16'h0080);
    wcfg(16'h0880);
    run(2, 1'b0, "R11 rejected");
    cyc(1'b0, 1'b0, 1'b0, 20'h00020, "R11 still async");
    run(6, 1'b0, "R11 still async");

    // R2 R3 R4 R8: sync, latency 3, 4 beats, wrap, rising edge
    wcfg(16'h1080);
    cyc(1'b1, 1'b0, 1'b0, 20'h00040, "R3 no start with ce high");
    run(5, 1'b0, "R3 no start with ce high");
    cyc(1'b0, 1'b0, 1'b0, 20'h00006, "R3 latch");
    run(10, 1'b0, "R2/R4/R6/R8 wrap short");

    // R5 R6: no wrap, 8 beats crossing the group
    wcfg(16'h108C);
    cyc(1'b0, 1'b0, 1'b0, 20'h00006, "R5 latch");
    run(14, 1'b0, "R5/R6 nowrap long");

    // R7: holds, with wrap and 8 beats
    wcfg(16'h1884);
    cyc(1'b0, 1'b0, 1'b0, 20'h0000D, "R7 latch");
    run(5, 1'b0, "R7 lead");
    run(3, 1'b1, "R7 hold");
    run(2, 1'b0, "R7 step");
    run(2, 1'b1, "R7 hold");
    run(8, 1'b0, "R7 tail");

    // R9: early ready
    wcfg(16'h1280);
    cyc(1'b0, 1'b0, 1'b0, 20'h00101, "R9 latch");
    run(4, 1'b0, "R9 early ready");
    run(2, 1'b1, "R9 early ready hold");
    run(5, 1'b0, "R9 early ready");

    // R10: falling-edge presentation, latency 8
    wcfg(16'h3800);
    cyc(1'b0, 1'b0, 1'b0, 20'h00F3, "R10 latch");
    run(14, 1'b0, "R10 falling edge");

    // R12: chip enable released mid burst
    wcfg(16'h1080);
    cyc(1'b0, 1'b0, 1'b0, 20'h00200, "R12 latch");
    run(4, 1'b0, "R12 lead");
    cyc(1'b1, 1'b1, 1'b0, '0, "R12 ce high");
    run(4, 1'b0, "R12 after ce");

    // R13: relatch mid burst and mid wait
    cyc(1'b0, 1'b0, 1'b0, 20'h00300, "R13 latch");
    run(4, 1'b0, "R13 lead");
    cyc(1'b0, 1'b0, 1'b0, 20'h00405, "R13 relatch burst");
    run(1, 1'b0, "R13 wait");
    cyc(1'b0, 1'b0, 1'b0, 20'h00502, "R13 relatch wait");
    run(8, 1'b0, "R13 restart");

    // R11: rejected write leaves latency of 3 in force
    wcfg(16'h0180);
    cyc(1'b0, 1'b0, 1'b0, 20'h00600, "R11 old cfg");
    run(7, 1'b0, "R11 old cfg");

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [15:0] w;
      int span;
      w = 16'(($urandom % 6 + 2) << 11);
      w[15] = ($urandom % 10) == 0;
      w[9]  = $urandom % 2;
      w[7]  = $urandom % 2;
      w[3]  = $urandom % 2;
      w[2]  = $urandom % 2;
      wcfg(w);
      if (($urandom % 20) == 0) wcfg(16'($urandom % 2) << 11);
      cyc(1'b0, 1'b0, $urandom % 2, AW'($urandom), "R2/R3 random latch");
      span = int'(m_cfg[13:11]) + 22;
      for (int c = 0; c < span; c++) begin
        int r;
        r = $urandom % 100;
        if (r < 3)      cyc(1'b1, 1'b1, 1'b0, '0, "R12 random");
        else if (r < 6) cyc(1'b0, 1'b0, 1'b0, AW'($urandom), "R13 random");
        else            cyc(1'b0, 1'b1, (r % 4) == 0, '0, "R2/R7 random");
      end
      cyc(1'b1, 1'b1, 1'b1, '0, "R12 random end");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule